// File: doc/BRIEF.md
# Multichannel Converter Scan Master

This block is the host-side master for a 16-bit successive-approximation converter with an 8-way input multiplexer and a 14-bit serial configuration register. While `run` is high it starts a conversion at a fixed period by raising `cnv`. It does not use a busy indicator, so it holds `cnv` high for the full worst-case conversion time. It then lowers `cnv` and runs one serial burst on `sck`. The burst shifts the 16-bit result in from `sdo`. When read-back is on, it also shifts in the 14-bit configuration echo. In the same burst it shifts the next configuration word out on `din`.

The configuration words come from a small host-written table. The block steps through the table one entry per conversion and wraps at a programmable length. A word shifted in after conversion k only governs conversion k+2. The block therefore carries a two-stage tag pipeline, and every result it delivers is labelled with the configuration that produced it: channel number and range polarity. A word whose commit bit (bit 13) is zero leaves the device configuration unchanged, and the tag pipeline follows that rule too. Until a committed word has reached the converter, the results are marked unsettled.

Top module: `adc_scan_master`

## Requirements
- R1: While reset is held, and on leaving reset, `cnv`, `sck` and `din` are low and `sampleValid` is low.
- R2: While running, `cnv` rises once every `CYCLE_CLKS` clocks and stays high for exactly `CONV_CLKS` clocks.
- R3: `sck` and `din` stay low for as long as `cnv` is high, and for at least `QUIET_CLKS` clocks before each rising edge of `cnv`.
- R4: One clock after `cnv` falls, a burst of 16 `sck` pulses starts. The burst has 30 pulses if `readbackEn` was high when it started. `sck` idles low and each of its phases lasts `SCK_HALF` clocks.
- R5: `din` carries the selected 14-bit table word MSB first. It changes only on `sck` falling edges, so it is stable at each rising edge. It is low for the bits after the 14th.
- R6: Table entries are sent in index order, one per conversion. After entry `tableLen-1` the index returns to 0, and a `tableLen` of 0 behaves like 1.
- R7: `sdo` is sampled at each `sck` falling edge, MSB first. `sampleData` holds the first 16 bits. `sampleReadback` holds the next 14 bits in read-back bursts and is zero otherwise.
- R8: The result of conversion k is tagged with the last word, among those sent in bursts 0..k-2, whose bit 13 is 1. `sampleCfg` is that word, `sampleChan` is its bits 9:7, and `sampleBipolar` is 1 when its bit 12 is 0.
- R9: `sampleSettled` is low for the first two results after reset, and stays low until a word with bit 13 set governs the conversion.
- R10: `sampleValid` is a one-clock pulse, `CONV_CLKS + 2 + 2*SCK_HALF*bits` clocks after the `cnv` rise of its conversion.
- R11: When `run` falls, the current period is completed. After that, `cnv` and `sck` stay low and no result is produced until `run` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enable continuous scanning |
| readbackEn | input | 1 | Extend bursts to fetch the 14-bit configuration echo |
| tableLen | input | $clog2(DEPTH+1) | Number of table entries in the scan loop |
| cfgWrEn | input | 1 | Table write strobe |
| cfgWrAddr | input | $clog2(DEPTH) | Table write index |
| cfgWrData | input | 14 | Table write word |
| cnv | output | 1 | Conversion start / frame line to the converter |
| sck | output | 1 | Serial clock to the converter |
| din | output | 1 | Serial configuration data to the converter |
| sdo | input | 1 | Serial result data from the converter |
| sampleValid | output | 1 | One-clock strobe for a new result |
| sampleData | output | 16 | Conversion result |
| sampleCfg | output | 14 | Configuration word that governed the result |
| sampleChan | output | 3 | Channel field of that configuration |
| sampleBipolar | output | 1 | Result is two's complement |
| sampleSettled | output | 1 | Tag is known to be correct |
| sampleReadback | output | 14 | Configuration echo (read-back bursts only) |

## Verification
Three things can fall on the same clock at the end of a burst: the last result bit is captured, the tag pipeline advances, and a no-commit word is treated as a hold. The bench provokes this by placing a no-commit entry in the table next to committed ones, in both burst lengths. It judges the outcome by rebuilding the commit chain arithmetically and comparing it with the tags and with the channel and polarity that the converter model encodes into each result. A second coincidence is the index wrap landing on the burst start when `tableLen` is zero or one. That case is judged from the words the model captures on `din`.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // Field positions inside a configuration word decoded by the tag logic
  localparam int CFG_BITS   = 14;
  localparam int COMMIT_BIT = 13;
  localparam int RANGE_BIT  = 12;
  localparam int CHAN_HI    = 9;
  localparam int CHAN_LO    = 7;

  typedef struct packed {
    logic load;     // burst begins: fetch table word, clear receive shifter
    logic sckFall;  // sck falls at this edge: sample sdo, advance din
    logic publish;  // last bit captured: present result and shift tags
    logic rbMode;   // current burst includes the configuration echo
  } scan_strobe_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CYCLE_CLKS = 400,
  parameter int CONV_CLKS  = 230,
  parameter int SCK_HALF   = 2,
  parameter int DATA_W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         readbackEn,
  output logic         cnv,
  output logic         sck,
  output scan_strobe_t strobe
);
  localparam int PW        = $clog2(CYCLE_CLKS);
  localparam int HW        = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int FULL_BITS = DATA_W + CFG_BITS;
  localparam int BW        = $clog2(FULL_BITS + 1);

  logic [PW-1:0] periodCnt;
  logic          idle;
  logic          cnvQ;
  logic          inBurst;
  logic [HW-1:0] halfCnt;
  logic [BW-1:0] bitCnt;
  logic          sckQ;
  logic          rbQ;
  logic          publishQ;

  logic          periodEnd, halfEnd, burstStart, fallNow, lastFall;
  logic [BW-1:0] lastBit;

  always_comb begin
    periodEnd  = periodCnt == PW'(CYCLE_CLKS - 1);
    halfEnd    = halfCnt == HW'(SCK_HALF - 1);
    lastBit    = rbQ ? BW'(FULL_BITS - 1) : BW'(DATA_W - 1);
    burstStart = !idle && (periodCnt == PW'(CONV_CLKS));
    fallNow    = inBurst && halfEnd && sckQ;
    lastFall   = fallNow && (bitCnt == lastBit);
  end

  // Conversion period: idle parks the counter on its last value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= PW'(CYCLE_CLKS - 1);
      idle      <= 1'b1;
      cnvQ      <= 1'b0;
    end else if (idle || periodEnd) begin
      if (run) begin
        idle      <= 1'b0;
        periodCnt <= '0;
        cnvQ      <= 1'b1;
      end else begin
        idle      <= 1'b1;
        cnvQ      <= 1'b0;
      end
    end else begin
      periodCnt <= periodCnt + 1'b1;
      cnvQ      <= (32'(periodCnt) + 1) < CONV_CLKS;
    end
  end

  // Serial burst sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBurst  <= 1'b0;
      halfCnt  <= '0;
      bitCnt   <= '0;
      sckQ     <= 1'b0;
      rbQ      <= 1'b0;
      publishQ <= 1'b0;
    end else begin
      publishQ <= lastFall;
      if (burstStart) begin
        inBurst <= 1'b1;
        halfCnt <= '0;
        bitCnt  <= '0;
        sckQ    <= 1'b0;
        rbQ     <= readbackEn;
      end else if (inBurst) begin
        if (halfEnd) begin
          halfCnt <= '0;
          sckQ    <= !sckQ;
          if (sckQ) begin
            if (lastFall) inBurst <= 1'b0;
            else          bitCnt  <= bitCnt + 1'b1;
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  assign cnv            = cnvQ;
  assign sck            = sckQ;
  assign strobe.load    = burstStart;
  assign strobe.sckFall = fallNow;
  assign strobe.publish = publishQ;
  assign strobe.rbMode  = rbQ;
endmodule

// File: rtl/adc_scan_data.sv
module adc_scan_data
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  scan_strobe_t        strobe,
  input  logic                cfgWrEn,
  input  logic [AW-1:0]       cfgWrAddr,
  input  logic [CFG_BITS-1:0] cfgWrData,
  input  logic [LW-1:0]       tableLen,
  input  logic                sdo,
  output logic                din,
  output logic                sampleValid,
  output logic [DATA_W-1:0]   sampleData,
  output logic [CFG_BITS-1:0] sampleCfg,
  output logic [2:0]          sampleChan,
  output logic                sampleBipolar,
  output logic                sampleSettled,
  output logic [CFG_BITS-1:0] sampleReadback
);
  localparam int FULL_BITS = DATA_W + CFG_BITS;

  logic [CFG_BITS-1:0]  cfgTable [DEPTH];
  logic [AW-1:0]        idx;
  logic [CFG_BITS-1:0]  txReg;
  logic [FULL_BITS-1:0] rxReg;
  logic [CFG_BITS-1:0]  sentWord;
  logic [CFG_BITS-1:0]  tagNear, tagFar;
  logic                 tagNearOk, tagFarOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cfgTable[i] <= '0;
    end else if (cfgWrEn) begin
      cfgTable[cfgWrAddr] <= cfgWrData;
    end
  end

  // Shifters and table walk
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      txReg    <= '0;
      rxReg    <= '0;
      sentWord <= '0;
    end else if (strobe.load) begin
      txReg    <= cfgTable[idx];
      sentWord <= cfgTable[idx];
      rxReg    <= '0;
      idx      <= (int'(idx) + 1 >= int'(tableLen)) ? '0 : idx + 1'b1;
    end else if (strobe.sckFall) begin
      txReg <= {txReg[CFG_BITS-2:0], 1'b0};
      rxReg <= {rxReg[FULL_BITS-2:0], sdo};
    end
  end

  // Two-conversion tag pipeline and result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagNear        <= '0;
      tagFar         <= '0;
      tagNearOk      <= 1'b0;
      tagFarOk       <= 1'b0;
      sampleValid    <= 1'b0;
      sampleData     <= '0;
      sampleCfg      <= '0;
      sampleChan     <= '0;
      sampleBipolar  <= 1'b0;
      sampleSettled  <= 1'b0;
      sampleReadback <= '0;
    end else begin
      sampleValid <= strobe.publish;
      if (strobe.publish) begin
        sampleData     <= strobe.rbMode ? rxReg[FULL_BITS-1:CFG_BITS] : rxReg[DATA_W-1:0];
        sampleReadback <= strobe.rbMode ? rxReg[CFG_BITS-1:0] : '0;
        sampleCfg      <= tagFar;
        sampleChan     <= tagFar[CHAN_HI:CHAN_LO];
        sampleBipolar  <= !tagFar[RANGE_BIT];
        sampleSettled  <= tagFarOk;
        tagFar         <= tagNear;
        tagFarOk       <= tagNearOk;
        if (sentWord[COMMIT_BIT]) begin
          tagNear   <= sentWord;
          tagNearOk <= 1'b1;
        end
      end
    end
  end

  assign din = txReg[CFG_BITS-1];
endmodule

// File: rtl/adc_scan_master.sv
module adc_scan_master
  import adc_scan_pkg::*;
#(
  parameter int CYCLE_CLKS = 400,
  parameter int CONV_CLKS  = 230,
  parameter int SCK_HALF   = 2,
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 8,
  localparam int AW        = $clog2(DEPTH),
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                run,
  input  logic                readbackEn,
  input  logic [LW-1:0]       tableLen,
  input  logic                cfgWrEn,
  input  logic [AW-1:0]       cfgWrAddr,
  input  logic [CFG_BITS-1:0] cfgWrData,
  output logic                cnv,
  output logic                sck,
  output logic                din,
  input  logic                sdo,
  output logic                sampleValid,
  output logic [DATA_W-1:0]   sampleData,
  output logic [CFG_BITS-1:0] sampleCfg,
  output logic [2:0]          sampleChan,
  output logic                sampleBipolar,
  output logic                sampleSettled,
  output logic [CFG_BITS-1:0] sampleReadback
);
  scan_strobe_t strobe;

  adc_scan_ctrl #(
    .CYCLE_CLKS(CYCLE_CLKS), .CONV_CLKS(CONV_CLKS),
    .SCK_HALF(SCK_HALF), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .readbackEn(readbackEn),
    .cnv(cnv), .sck(sck), .strobe(strobe)
  );

  adc_scan_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .tableLen(tableLen), .sdo(sdo), .din(din),
    .sampleValid(sampleValid), .sampleData(sampleData), .sampleCfg(sampleCfg),
    .sampleChan(sampleChan), .sampleBipolar(sampleBipolar),
    .sampleSettled(sampleSettled), .sampleReadback(sampleReadback)
  );
endmodule

// File: rtl/adc_scan_master_chk.sv
module adc_scan_master_chk #(
  parameter int CYCLE_CLKS = 400,
  parameter int CONV_CLKS  = 230,
  parameter int QUIET_CLKS = 4
) (
  input logic clk,
  input logic rstN,
  input logic cnv,
  input logic sck,
  input logic din,
  input logic sampleValid
);
  localparam int SAT = 1 << 20;

  logic cnvD, seenRise;
  int   sinceRise, highCnt, quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnvD      <= 1'b0;
      seenRise  <= 1'b0;
      sinceRise <= 0;
      highCnt   <= 0;
      quietCnt  <= QUIET_CLKS;
    end else begin
      cnvD      <= cnv;
      seenRise  <= seenRise | (cnv && !cnvD);
      sinceRise <= (cnv && !cnvD) ? 1 : ((sinceRise < SAT) ? sinceRise + 1 : sinceRise);
      highCnt   <= cnv ? highCnt + 1 : 0;
      quietCnt  <= (sck || din) ? 0 : ((quietCnt < SAT) ? quietCnt + 1 : quietCnt);
    end
  end

  AST_CNV_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cnv) && seenRise |-> sinceRise >= CYCLE_CLKS);  // R2
  AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cnv) |-> highCnt == CONV_CLKS);  // R2
  AST_QUIET_BEFORE_CNV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cnv) |-> quietCnt >= QUIET_CLKS);  // R3
  AST_SCK_DIN_IDLE_IN_CNV: assert property (@(posedge clk) disable iff (!rstN)
    cnv |-> !sck && !din);  // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);  // R10
endmodule

bind adc_scan_master adc_scan_master_chk #(
  .CYCLE_CLKS(CYCLE_CLKS), .CONV_CLKS(CONV_CLKS)
) u_chk (
  .clk(clk), .rstN(rstN), .cnv(cnv), .sck(sck), .din(din), .sampleValid(sampleValid)
);

// File: tb/adc_scan_master_bench.sv
module adc_scan_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CYCLE = 400;
  localparam int CONV  = 230;
  localparam int HALF  = 2;
  localparam int QUIET = 4;
  localparam int DEPTH = 8;
  localparam int MAXK  = 64;

  logic clk = 0, rstN = 0, run = 0, readbackEn = 0;
  logic [3:0] tableLen = 0;
  logic cfgWrEn = 0;
  logic [2:0] cfgWrAddr = 0;
  logic [13:0] cfgWrData = 0;
  logic cnv, sck, din, sdo;
  logic sampleValid, sampleBipolar, sampleSettled;
  logic [15:0] sampleData;
  logic [13:0] sampleCfg, sampleReadback;
  logic [2:0] sampleChan;

  adc_scan_master #(.CYCLE_CLKS(CYCLE), .CONV_CLKS(CONV), .SCK_HALF(HALF), .DEPTH(DEPTH))
  u_adc_scan_master (
    .clk(clk), .rstN(rstN), .run(run), .readbackEn(readbackEn), .tableLen(tableLen),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .cnv(cnv), .sck(sck), .din(din), .sdo(sdo),
    .sampleValid(sampleValid), .sampleData(sampleData), .sampleCfg(sampleCfg),
    .sampleChan(sampleChan), .sampleBipolar(sampleBipolar),
    .sampleSettled(sampleSettled), .sampleReadback(sampleReadback)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench copy of the host table and expected scoreboard
  logic [13:0] tbl [DEPTH];
  logic [13:0] sentExp [MAXK];
  logic [13:0] effExp [MAXK];
  bit          effOk [MAXK];
  bit          burstRb [MAXK];
  int          benchIdx = 0;

  // Converter model
  logic [13:0] devActive = 0, devPending = 0, devUsed = 0;
  logic [15:0] devData = 0;
  logic [29:0] devOut = 0;
  int devInBits = 0, sckRises = 0, convIdx = 0;
  assign sdo = devOut[29];

  always @(posedge cnv) begin
    if (convIdx > 0 && convIdx <= MAXK) begin
      check(sckRises == (burstRb[convIdx-1] ? 30 : 16), "R4", "sck pulses per burst",
            sckRises, burstRb[convIdx-1] ? 30 : 16);
      check(devPending == sentExp[convIdx-1], "R5 R6", "word on din",
            devPending, sentExp[convIdx-1]);
    end
    devUsed = devActive;
    devData = {12'(convIdx), ~devActive[12], devActive[9:7]};
    if (devInBits >= 14 && devPending[13]) devActive = devPending;
    sckRises = 0; devInBits = 0; devPending = 0;
    if (convIdx < MAXK) begin
      sentExp[convIdx] = tbl[benchIdx];
      burstRb[convIdx] = readbackEn;
      benchIdx = (benchIdx + 1 >= int'(tableLen)) ? 0 : benchIdx + 1;
      if (convIdx < 2) begin
        effExp[convIdx] = 0; effOk[convIdx] = 0;
      end else if (sentExp[convIdx-2][13]) begin
        effExp[convIdx] = sentExp[convIdx-2]; effOk[convIdx] = 1;
      end else begin
        effExp[convIdx] = effExp[convIdx-1]; effOk[convIdx] = effOk[convIdx-1];
      end
    end
    convIdx++;
  end
  always @(negedge cnv) devOut = {devData, devUsed};
  always @(posedge sck) begin
    sckRises++;
    if (devInBits < 14) begin devPending = {devPending[12:0], din}; devInBits++; end
  end
  always @(negedge sck) devOut = devOut << 1;

  // Monitor, sampled away from the active edge
  int cyc = 0, lastBusy = -100, riseCyc = 0, lastRise = 0, sckHigh = 0, sIdx = 0;
  bit prevCnv = 0, prevSck = 0, haveRise = 0;
  always @(negedge clk) begin
    cyc++;
    if (cnv && !prevCnv) begin
      check(cyc - lastBusy > QUIET, "R3", "quiet clocks before cnv rise", cyc - lastBusy, QUIET + 1);
      if (haveRise) check(cyc - lastRise == CYCLE, "R2", "cnv period", cyc - lastRise, CYCLE);
      haveRise = 1; lastRise = cyc; riseCyc = cyc;
    end
    if (!cnv && prevCnv) begin
      check(cyc - riseCyc == CONV, "R2", "cnv high width", cyc - riseCyc, CONV);
      check(!sck && !din, "R3", "sck/din idle at cnv fall", {sck, din}, 0);
    end
    if (sck) sckHigh++;
    if (!sck && prevSck) begin
      if (sckHigh != HALF) check(0, "R4", "sck high phase", sckHigh, HALF);
      sckHigh = 0;
    end
    if (sck || din) lastBusy = cyc;
    if (sampleValid && sIdx < MAXK) begin
      automatic int k = sIdx;
      automatic int bits = burstRb[k] ? 30 : 16;
      automatic logic [13:0] e = effExp[k];
      check(cyc - riseCyc == CONV + 2 + 2*HALF*bits, "R10", "valid latency",
            cyc - riseCyc, CONV + 2 + 2*HALF*bits);
      check(sampleSettled == effOk[k], "R9", "settled flag", sampleSettled, effOk[k]);
      check(sampleData[15:4] == 12'(k), "R7", "result upper bits", sampleData[15:4], 12'(k));
      if (!burstRb[k]) check(sampleReadback == 0, "R7", "readback without echo", sampleReadback, 0);
      if (effOk[k]) begin
        check(sampleCfg == e, "R8", "tag word", sampleCfg, e);
        check(sampleChan == e[9:7], "R8", "tag channel", sampleChan, e[9:7]);
        check(sampleBipolar == ~e[12], "R8", "tag polarity", sampleBipolar, ~e[12]);
        check(sampleData[3:0] == {~e[12], e[9:7]}, "R7", "result low bits",
              sampleData[3:0], {~e[12], e[9:7]});
        if (burstRb[k]) check(sampleReadback == e, "R7", "echo word", sampleReadback, e);
      end
      sIdx++;
    end
    prevCnv = cnv; prevSck = sck;
  end

  function automatic logic [13:0] mk(input bit commit, input logic [2:0] incc, input logic [2:0] ch);
    return {commit, incc, ch, 7'b1111001};
  endfunction

  task automatic wrTable(input int a, input logic [13:0] w);
    @(negedge clk);
    cfgWrEn = 1; cfgWrAddr = 3'(a); cfgWrData = w; tbl[a] = w;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic runFor(input int n);
    run = 1;
    while (sIdx < n) @(negedge clk);
    run = 0;
    repeat (2*CYCLE) @(negedge clk);
  endtask

  task automatic checkStopped();
    automatic int c0 = convIdx, s0 = sIdx;
    repeat (3*CYCLE) @(negedge clk);
    check(convIdx == c0 && !cnv, "R11", "no conversion while stopped", convIdx, c0);
    check(sIdx == s0, "R11", "no result while stopped", sIdx, s0);
    haveRise = 0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl[i] = 0;
    repeat (3) @(negedge clk);
    check(!cnv && !sck && !din && !sampleValid, "R1", "outputs in reset", {cnv, sck, din, sampleValid}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(!cnv && !sck && !din && !sampleValid, "R1", "outputs after reset", {cnv, sck, din, sampleValid}, 0);

    // Phase A: four committed words, short bursts
    wrTable(0, mk(1, 3'b111, 3'd5));
    wrTable(1, mk(1, 3'b010, 3'd2));
    wrTable(2, mk(1, 3'b110, 3'd7));
    wrTable(3, mk(1, 3'b000, 3'd0));
    tableLen = 4; readbackEn = 0;
    runFor(10);
    checkStopped();

    // Phase B: a hold word in the loop, echo bursts
    wrTable(0, mk(0, 3'b001, 3'd3));
    wrTable(1, mk(1, 3'b011, 3'd1));
    wrTable(2, mk(1, 3'b111, 3'd6));
    tableLen = 3; readbackEn = 1;
    runFor(sIdx + 12);
    checkStopped();

    // Phase C: zero length behaves as one entry
    wrTable(0, mk(1, 3'b100, 3'd4));
    tableLen = 0; readbackEn = 0;
    runFor(sIdx + 8);
    checkStopped();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule